// File: doc/BRIEF.md
# Multiprocessor-Capable Asynchronous Serial Receiver

This block turns an asynchronous serial line into received words. Each frame is a low start bit, the data bits sent least significant first, an optional ninth bit, and a high stop bit. The bit rate comes from a strobe that an external divider raises once per sixteenth of a bit period. The block samples the middle of every bit, votes over three samples and moves each finished frame into a holding register. Software reads that register and then acknowledges it.

In nine-bit mode the receiver can act as one station on a shared bus. With filtering switched on, only frames whose ninth bit is 1 (address frames) reach the holding register. Frames whose ninth bit is 0 are thrown away without touching any output. With filtering off, every frame is kept and the ninth bit is passed on for software parity checks.

The block flags a bad stop bit, and it flags a frame lost because the previous one had not been read. The overrun flag stays set until the receive enable is driven low. An idle status output shows whether a frame is in progress.

Top module: `addr_uart_rx`

## Requirements
- R1: After reset, `rx_idle` is 1, `data_valid`, `frame_err` and `overrun_err` are 0, and `rx_data` and `rx_bit8` are 0.
- R2: An 8-bit frame (start 0, data LSB first, stop 1) loads `rx_data` and sets `data_valid`. The load is visible after the second clock edge following the tick that samples the middle of the stop bit.
- R3: With `nine_bit_sel` = 1, the bit after the eight data bits is stored in `rx_bit8`. In 8-bit mode `rx_bit8` is loaded as 0.
- R4: With `nine_bit_sel` = 1 and `addr_filter_en` = 1, a frame whose ninth bit is 0 changes no output, and a frame whose ninth bit is 1 is loaded normally.
- R5: With `addr_filter_en` = 0, every nine-bit frame is loaded whatever its ninth bit.
- R6: `frame_err` takes the inverse of the sampled stop bit each time a frame is loaded, so a later good frame clears it.
- R7: When a frame is accepted while `data_valid` is 1 and no `rd_ack` arrives in the same cycle, `overrun_err` is set and `rx_data`, `rx_bit8` and `frame_err` keep their values.
- R8: `overrun_err` is cleared only by a clock edge with `rx_enable` = 0. `rd_ack` leaves it set.
- R9: `rx_idle` is 0 from start-bit detection until the stop bit is sampled. It is 1 whenever `rx_enable` is 0.
- R10: With `rx_invert` = 1, the line level is complemented before any sampling, so the idle level and every bit are inverted.
- R11: Each bit value is the majority of three samples taken on consecutive ticks at the middle of the bit, so a one-tick glitch there does not change the bit.
- R12: A low level that has gone back high by the middle of the start bit returns the receiver to idle and loads nothing.
- R13: A one-cycle `rd_ack` clears `data_valid` at the next edge unless a frame is loaded on that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| os_tick | input | 1 | One-cycle strobe, 16 per bit period |
| rx_line | input | 1 | Serial input line (asynchronous) |
| rx_enable | input | 1 | Receiver enable; low holds the receiver idle and clears overrun |
| nine_bit_sel | input | 1 | 1 selects nine-bit frames |
| addr_filter_en | input | 1 | 1 drops nine-bit frames whose ninth bit is 0 |
| rx_invert | input | 1 | 1 complements the line level |
| rd_ack | input | 1 | One-cycle strobe: holding register consumed |
| rx_data | output | 8 | Received data byte |
| rx_bit8 | output | 1 | Received ninth bit |
| data_valid | output | 1 | Holding register holds an unread frame |
| frame_err | output | 1 | Loaded frame had a low stop bit |
| overrun_err | output | 1 | A frame was lost to an unread holding register |
| rx_idle | output | 1 | No frame in progress |

## Verification
The line passes through two synchronizer flops, so a level driven at the line is voted on the third tick-carrying edge after it. Start detection drops `rx_idle` on the edge of the detecting tick. Frame results land one edge after the stop-bit decision. A read strobe or an enable drop acts on the next edge. The bench starts every frame one clock after a tick, so each sample falls on a known clock of the bit. That lets it place glitches and short stop bits on exact samples. A timed reference model predicts every output at every falling edge, and directed checks read the outputs a few clocks after each frame has settled.

// File: rtl/addr_uart_rx_pkg.sv
// Package: shared types and helpers for the serial receiver.
// Assumes: nothing beyond IEEE 1800-2017.
package addr_uart_rx_pkg;

    // Frame-level receive state
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_START = 2'd1,
        ST_DATA  = 2'd2,
        ST_STOP  = 2'd3
    } rx_state_e;

    // Two-of-three vote
    function automatic logic majority3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

endpackage

// File: rtl/rx_line_sampler.sv
// Module: rx_line_sampler
// Brings the asynchronous line into the clock domain through SYNC_STAGES flops.
// Applies the polarity select and keeps the two previous tick samples, so a
// three-sample majority of the current level is always available.
// Assumes: os_tick is a one-cycle strobe; idle line level is high before inversion.
module rx_line_sampler
    import addr_uart_rx_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic os_tick,
    input  logic rx_line,
    input  logic rx_invert,
    output logic line_lvl,
    output logic vote
);

    logic [SYNC_STAGES-1:0] sync_q;
    logic [1:0]             hist_q;

    // Synchronizer chain, reset to the idle level
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], rx_line};
    end

    assign line_lvl = sync_q[SYNC_STAGES-1] ^ rx_invert;

    // Sample history, advanced on every tick
    always_ff @(posedge clk) begin
        if (!rst_n)       hist_q <= 2'b11;
        else if (os_tick) hist_q <= {hist_q[0], line_lvl};
    end

    assign vote = majority3(hist_q[1], hist_q[0], line_lvl);

    // R11: three equal samples must produce that value
    p_vote_unanimous_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (hist_q == 2'b00 && !line_lvl) |-> !vote);

endmodule

// File: rtl/rx_frame_ctrl.sv
// Module: rx_frame_ctrl
// Finds the start bit, confirms it at mid-bit, shifts in the data bits LSB
// first (and the ninth bit when selected), then samples the stop bit.
// Emits a one-cycle done pulse with the assembled word and the stop level.
// Assumes: OVS is a power of two, so the tick counter wraps once per bit.
module rx_frame_ctrl
    import addr_uart_rx_pkg::*;
#(
    parameter int OVS    = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              os_tick,
    input  logic              rx_enable,
    input  logic              nine_bit_sel,
    input  logic              line_lvl,
    input  logic              vote,
    output logic              state_idle,
    output logic              frm_done,
    output logic [DATA_W-1:0] frm_data,
    output logic              frm_bit8,
    output logic              frm_stop_ok
);

    localparam int CNT_W = $clog2(OVS);
    localparam int IDX_W = $clog2(DATA_W + 1);
    localparam logic [CNT_W-1:0] MID   = CNT_W'(OVS / 2);
    localparam logic [IDX_W-1:0] LAST8 = IDX_W'(DATA_W - 1);
    localparam logic [IDX_W-1:0] LAST9 = IDX_W'(DATA_W);

    rx_state_e          state_q;
    logic [CNT_W-1:0]   cnt_q;
    logic [IDX_W-1:0]   idx_q;
    logic [DATA_W:0]    shreg_q;
    logic [IDX_W-1:0]   last_idx;

    assign last_idx = nine_bit_sel ? LAST9 : LAST8;

    // Frame sequencing: tick counting, bit capture and completion pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            cnt_q       <= '0;
            idx_q       <= '0;
            shreg_q     <= '0;
            frm_done    <= 1'b0;
            frm_stop_ok <= 1'b1;
        end else begin
            frm_done <= 1'b0;
            if (!rx_enable) begin
                state_q <= ST_IDLE;
            end else if (os_tick) begin
                if (state_q == ST_IDLE) begin
                    if (!line_lvl) begin
                        state_q <= ST_START;
                        cnt_q   <= CNT_W'(1);
                    end
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                    if (cnt_q == MID) begin
                        case (state_q)
                            ST_START: begin
                                if (!vote) begin
                                    state_q <= ST_DATA;
                                    idx_q   <= '0;
                                    shreg_q <= '0;
                                end else begin
                                    state_q <= ST_IDLE;
                                end
                            end
                            ST_DATA: begin
                                shreg_q[idx_q] <= vote;
                                idx_q          <= idx_q + 1'b1;
                                if (idx_q == last_idx) state_q <= ST_STOP;
                            end
                            ST_STOP: begin
                                frm_done    <= 1'b1;
                                frm_stop_ok <= vote;
                                state_q     <= ST_IDLE;
                            end
                            default: state_q <= ST_IDLE;
                        endcase
                    end
                end
            end
        end
    end

    assign state_idle = (state_q == ST_IDLE);
    assign frm_data   = shreg_q[DATA_W-1:0];
    assign frm_bit8   = shreg_q[DATA_W];

    // R9: a disabled receiver is idle at the next edge
    p_disabled_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_enable |=> state_idle);

    // R2: completion is a single-cycle pulse
    p_done_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        frm_done |=> !frm_done);

endmodule

// File: rtl/rx_hold_reg.sv
// Module: rx_hold_reg
// Holding register with address filtering, framing and overrun flags.
// A done pulse whose frame passes the filter either loads the register or,
// if the previous word is unread, raises overrun and is discarded.
// Assumes: frm_* are stable while frm_done is high.
module rx_hold_reg #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_enable,
    input  logic              nine_bit_sel,
    input  logic              addr_filter_en,
    input  logic              rd_ack,
    input  logic              frm_done,
    input  logic [DATA_W-1:0] frm_data,
    input  logic              frm_bit8,
    input  logic              frm_stop_ok,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_bit8,
    output logic              data_valid,
    output logic              frame_err,
    output logic              overrun_err
);

    logic accept;
    logic take;

    assign accept = !(nine_bit_sel && addr_filter_en && !frm_bit8);
    assign take   = frm_done && rx_enable && accept;

    // Load, overrun and read handling for the holding register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_data     <= '0;
            rx_bit8     <= 1'b0;
            data_valid  <= 1'b0;
            frame_err   <= 1'b0;
            overrun_err <= 1'b0;
        end else begin
            if (!rx_enable) overrun_err <= 1'b0;
            if (take) begin
                if (data_valid && !rd_ack) begin
                    overrun_err <= 1'b1;
                end else begin
                    rx_data    <= frm_data;
                    rx_bit8    <= frm_bit8;
                    frame_err  <= !frm_stop_ok;
                    data_valid <= 1'b1;
                end
            end else if (rd_ack) begin
                data_valid <= 1'b0;
            end
        end
    end

    // R4: a filtered-out frame leaves the data untouched
    p_drop_keeps_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_done && nine_bit_sel && addr_filter_en && !frm_bit8) |=> $stable(rx_data));

    // R2: an accepted frame into a free register is loaded
    p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (take && (!data_valid || rd_ack)) |=> (data_valid && rx_data == $past(frm_data)));

    // R7: a frame into an unread register raises overrun and is lost
    p_overrun_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (take && data_valid && !rd_ack) |=> (overrun_err && $stable(rx_data)));

    // R8: overrun only falls after a disabled cycle
    p_overrun_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(overrun_err) |-> $past(!rx_enable));

    // R13: a read without a simultaneous load empties the register
    p_read_clears_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ack && !take) |=> !data_valid);

endmodule

// File: rtl/addr_uart_rx.sv
// Module: addr_uart_rx (top)
// Asynchronous serial receiver with 8/9-bit frames, ninth-bit address
// filtering, framing and overrun flags and an idle status output.
// Assumes: os_tick pulses OVS times per bit period; rd_ack is a one-cycle strobe.
module addr_uart_rx #(
    parameter int OVS         = 16,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              os_tick,
    input  logic              rx_line,
    input  logic              rx_enable,
    input  logic              nine_bit_sel,
    input  logic              addr_filter_en,
    input  logic              rx_invert,
    input  logic              rd_ack,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_bit8,
    output logic              data_valid,
    output logic              frame_err,
    output logic              overrun_err,
    output logic              rx_idle
);

    logic              line_lvl;
    logic              vote;
    logic              frm_done;
    logic [DATA_W-1:0] frm_data;
    logic              frm_bit8;
    logic              frm_stop_ok;

    rx_line_sampler #(
        .SYNC_STAGES (SYNC_STAGES)
    ) u_sampler (
        .clk       (clk),
        .rst_n     (rst_n),
        .os_tick   (os_tick),
        .rx_line   (rx_line),
        .rx_invert (rx_invert),
        .line_lvl  (line_lvl),
        .vote      (vote)
    );

    rx_frame_ctrl #(
        .OVS    (OVS),
        .DATA_W (DATA_W)
    ) u_frame (
        .clk          (clk),
        .rst_n        (rst_n),
        .os_tick      (os_tick),
        .rx_enable    (rx_enable),
        .nine_bit_sel (nine_bit_sel),
        .line_lvl     (line_lvl),
        .vote         (vote),
        .state_idle   (rx_idle),
        .frm_done     (frm_done),
        .frm_data     (frm_data),
        .frm_bit8     (frm_bit8),
        .frm_stop_ok  (frm_stop_ok)
    );

    rx_hold_reg #(
        .DATA_W (DATA_W)
    ) u_hold (
        .clk            (clk),
        .rst_n          (rst_n),
        .rx_enable      (rx_enable),
        .nine_bit_sel   (nine_bit_sel),
        .addr_filter_en (addr_filter_en),
        .rd_ack         (rd_ack),
        .frm_done       (frm_done),
        .frm_data       (frm_data),
        .frm_bit8       (frm_bit8),
        .frm_stop_ok    (frm_stop_ok),
        .rx_data        (rx_data),
        .rx_bit8        (rx_bit8),
        .data_valid     (data_valid),
        .frame_err      (frame_err),
        .overrun_err    (overrun_err)
    );

endmodule

// File: tb/addr_uart_rx_bench.sv
// Bench: timed reference model compared at every falling edge, plus directed checks.
module addr_uart_rx_bench;

    localparam int BIT_CLK = 64;   // 16 ticks x 4 clocks

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       os_tick = 1'b0;
    logic       rx_line = 1'b1;
    logic       rx_enable = 1'b0;
    logic       nine_bit_sel = 1'b0;
    logic       addr_filter_en = 1'b0;
    logic       rx_invert = 1'b0;
    logic       rd_ack = 1'b0;
    logic [7:0] rx_data;
    logic       rx_bit8, data_valid, frame_err, overrun_err, rx_idle;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  cmp_on = 1'b0;
    bit  finished = 1'b0;
    bit  line_inv = 1'b0;
    int  div = 0;

    addr_uart_rx u_addr_uart_rx (
        .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rx_line(rx_line),
        .rx_enable(rx_enable), .nine_bit_sel(nine_bit_sel),
        .addr_filter_en(addr_filter_en), .rx_invert(rx_invert), .rd_ack(rd_ack),
        .rx_data(rx_data), .rx_bit8(rx_bit8), .data_valid(data_valid),
        .frame_err(frame_err), .overrun_err(overrun_err), .rx_idle(rx_idle)
    );

    always #10 clk = ~clk;   // 50 MHz

    // Oversampling strobe: one clock in four
    always @(negedge clk) begin
        os_tick = (div == 3);
        div = (div + 1) % 4;
    end

    // ---------------- reference model ----------------
    bit       m_s1, m_s2, m_line, m_vote, m_done, m_stop, m_take;
    bit [1:0] m_hist;
    bit [8:0] m_bits;
    int       m_pos, k, nb, np;
    bit [7:0] m_data;
    bit       m_b8, m_valid, m_fe, m_ov;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_s1 = 1; m_s2 = 1; m_hist = 2'b11; m_pos = -1; m_bits = 0;
            m_done = 0; m_stop = 1; m_data = 0; m_b8 = 0; m_valid = 0; m_fe = 0; m_ov = 0;
        end else begin
            m_line = m_s2 ^ rx_invert;
            // holding register per R4 R5 R6 R7 R8 R13
            if (!rx_enable) m_ov = 0;
            m_take = m_done && rx_enable && !(nine_bit_sel && addr_filter_en && !m_bits[8]);
            if (m_take) begin
                if (m_valid && !rd_ack) m_ov = 1;
                else begin m_data = m_bits[7:0]; m_b8 = m_bits[8]; m_fe = !m_stop; m_valid = 1; end
            end else if (rd_ack) m_valid = 0;
            // framing per R2 R3 R9 R11 R12
            m_done = 0;
            m_vote = m_line;
            if (os_tick) begin
                m_vote = (int'(m_hist[1]) + int'(m_hist[0]) + int'(m_line)) >= 2;
                m_hist = {m_hist[0], m_line};
            end
            if (!rx_enable) m_pos = -1;
            else if (os_tick) begin
                if (m_pos < 0) begin
                    if (!m_line) m_pos = 1;
                end else begin
                    np = m_pos + 1;
                    if (m_pos % 16 == 8) begin
                        k = m_pos / 16;
                        nb = nine_bit_sel ? 9 : 8;
                        if (k == 0) begin
                            if (m_vote) np = -1; else m_bits = 0;
                        end else if (k <= nb) m_bits[k-1] = m_vote;
                        else begin m_done = 1; m_stop = m_vote; np = -1; end
                    end
                    m_pos = np;
                end
            end
            m_s2 = m_s1;
            m_s1 = rx_line;
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Model comparison on every falling edge
    always @(negedge clk) begin
        if (cmp_on && !finished) begin
            chk("R2",  "rx_data",     rx_data,     m_data);
            chk("R3",  "rx_bit8",     rx_bit8,     m_b8);
            chk("R13", "data_valid",  data_valid,  m_valid);
            chk("R6",  "frame_err",   frame_err,   m_fe);
            chk("R7",  "overrun_err", overrun_err, m_ov);
            chk("R9",  "rx_idle",     rx_idle,     (m_pos < 0));
        end
    end

    // Frame driver: starts one clock after a tick; stop_len < BIT_CLK shortens the stop bit
    task automatic send_frame(input logic [8:0] val, input int nbits, input logic stop_lvl,
                              input int stop_len, input int glitch_bit);
        logic lvl;
        @(posedge clk);
        while (!os_tick) @(posedge clk);
        for (int b = 0; b < nbits + 2; b++) begin
            lvl = (b == 0) ? 1'b0 : (b == nbits + 1) ? stop_lvl : val[b-1];
            for (int c = 0; c < BIT_CLK; c++) begin
                @(negedge clk);
                if (b == nbits + 1 && c >= stop_len) rx_line = 1'b1 ^ line_inv;
                else rx_line = lvl ^ line_inv ^ ((b - 1 == glitch_bit && c >= 28 && c < 32) ? 1'b1 : 1'b0);
                if (b == 3 && c == 10) chk("R9", "busy idle", rx_idle, 0);
            end
        end
        @(negedge clk);
        rx_line = 1'b1 ^ line_inv;
        repeat (8) @(negedge clk);
    endtask

    task automatic do_read();
        @(negedge clk); rd_ack = 1'b1;
        @(negedge clk); rd_ack = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        cmp_on = 1'b1;
        // R1: reset state
        chk("R1", "idle", rx_idle, 1);
        chk("R1", "valid", data_valid, 0);
        chk("R1", "errs", {frame_err, overrun_err}, 0);
        chk("R1", "data", {rx_bit8, rx_data}, 0);
        rst_n = 1'b1; rx_enable = 1'b1;
        repeat (20) @(negedge clk);

        // R2: plain 8-bit frame
        send_frame(9'h0A5, 8, 1'b1, BIT_CLK, -1);
        chk("R2", "data", rx_data, 8'hA5);
        chk("R2", "valid", data_valid, 1);
        chk("R3", "bit8 in 8-bit mode", rx_bit8, 0);
        do_read();
        chk("R13", "valid after read", data_valid, 0);

        // R6: bad stop then good frame
        send_frame(9'h03C, 8, 1'b0, 36, -1);
        chk("R6", "ferr set", frame_err, 1);
        chk("R6", "data with ferr", rx_data, 8'h3C);
        do_read();
        send_frame(9'h05A, 8, 1'b1, BIT_CLK, -1);
        chk("R6", "ferr cleared", frame_err, 0);

        // R7/R8: overrun
        send_frame(9'h011, 8, 1'b1, BIT_CLK, -1);
        chk("R7", "overrun set", overrun_err, 1);
        chk("R7", "data kept", rx_data, 8'h5A);
        do_read();
        chk("R8", "overrun after read", overrun_err, 1);
        @(negedge clk); rx_enable = 1'b0;
        @(negedge clk); rx_enable = 1'b1;
        chk("R9", "idle when disabled", rx_idle, 1);
        @(negedge clk);
        chk("R8", "overrun cleared", overrun_err, 0);

        // R5/R3: nine-bit, no filter
        nine_bit_sel = 1'b1;
        send_frame(9'h077, 9, 1'b1, BIT_CLK, -1);
        chk("R5", "data b8=0 kept", rx_data, 8'h77);
        chk("R5", "valid", data_valid, 1);
        do_read();
        send_frame(9'h181, 9, 1'b1, BIT_CLK, -1);
        chk("R3", "ninth bit", rx_bit8, 1);
        chk("R3", "data", rx_data, 8'h81);
        do_read();

        // R4: address filter
        addr_filter_en = 1'b1;
        send_frame(9'h042, 9, 1'b1, BIT_CLK, -1);
        chk("R4", "dropped valid", data_valid, 0);
        chk("R4", "dropped data", rx_data, 8'h81);
        send_frame(9'h199, 9, 1'b1, BIT_CLK, -1);
        chk("R4", "address data", rx_data, 8'h99);
        chk("R4", "address valid", data_valid, 1);
        do_read();
        addr_filter_en = 1'b0; nine_bit_sel = 1'b0;

        // R10: inverted line
        @(negedge clk); line_inv = 1'b1; rx_invert = 1'b1; rx_line = 1'b0;
        repeat (100) @(negedge clk);
        send_frame(9'h06B, 8, 1'b1, BIT_CLK, -1);
        chk("R10", "inverted data", rx_data, 8'h6B);
        chk("R10", "inverted ferr", frame_err, 0);
        do_read();
        @(negedge clk); line_inv = 1'b0; rx_invert = 1'b0; rx_line = 1'b1;
        repeat (100) @(negedge clk);

        // R11: glitch on one sample of bit 2
        send_frame(9'h0C3, 8, 1'b1, BIT_CLK, 2);
        chk("R11", "glitched data", rx_data, 8'hC3);
        do_read();

        // R12: false start
        @(posedge clk);
        while (!os_tick) @(posedge clk);
        @(negedge clk); rx_line = 1'b0;
        repeat (8) @(negedge clk);
        rx_line = 1'b1;
        repeat (40) @(negedge clk);
        chk("R12", "idle after false start", rx_idle, 1);
        repeat (BIT_CLK * 10) @(negedge clk);
        chk("R12", "nothing loaded", data_valid, 0);

        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    // Watchdog
    initial begin
        #(200000 * 20);
        if (!finished) begin
            finished = 1'b1;
            n_fail++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule